// File: doc/BRIEF.md
# Multi-Pattern Bit-Error-Test Transmit Generator

This block produces a serial test stream for bit-error-rate measurement, one bit per accepted transfer. A host picks a pattern type: one of three maximal-length pseudorandom sequences, a quasi-random signal with long zero runs suppressed, a programmable repeating word of 1 to 32 bits, or two 16-bit words that alternate after a programmable number of repetitions.

The host sets the configuration inputs and pulses `load`. On that edge the block captures all configuration, seeds its generator and restarts every pattern from its first bit. Configuration inputs may change freely afterwards without effect until the next `load`. The stream leaves through a valid/ready pair: `bit_vld` rises on the cycle after the first `load` and stays high. The line side raises `bit_rdy` when it takes a bit. A bit is consumed on each rising edge where both are high, and the next bit appears on `bit_out` after that edge. While `bit_rdy` is low, `bit_out` and the generator state hold. `load` takes priority over a transfer on the same edge.

Top module: `bert_tx_gen`

## Requirements
- R1: After reset and before the first `load`, `bit_vld` and `bit_out` are both 0, whatever `bit_rdy` does.
- R2: `load` captures every configuration input, and `bit_vld` is 1 from the following cycle. Changing configuration inputs without `load` does not alter the stream.
- R3: The stream advances by one bit only on an edge with `bit_vld` and `bit_rdy` both high and `load` low. Otherwise `bit_out` holds.
- R4: Mode code 0 sends the x^7+x^6+1 sequence from an all-ones start: bits b0..b6 are 1 and b(k+7) = b(k) xor b(k+1). The period is 127 and the register never sits at zero.
- R5: Mode code 1 sends the x^11+x^9+1 sequence: b0..b10 are 1 and b(k+11) = b(k) xor b(k+2).
- R6: Mode code 2 sends the x^15+x^14+1 sequence: b0..b14 are 1 and b(k+15) = b(k) xor b(k+1).
- R7: Mode code 3 is quasi-random. The raw sequence has r0..r19 = 1 and r(k+20) = r(k) xor r(k+3). Bit k sent is r(k), except that it is 1 whenever r(k) through r(k+13) are all 0.
- R8: Mode code 4 repeats a word of L = `cfg_len`+1 bits (1 to 32). It sends `cfg_word` bits L-1 down to 0, then starts again with no gap.
- R9: Mode code 5 sends 16-bit words MSB first: `cfg_alt_a` N times, then `cfg_alt_b` N times, and so on, where N = `cfg_flip`+1. The stream starts on `cfg_alt_a`.
- R10: Mode codes 6 and 7 send a constant 0 while `bit_vld` is high.
- R11: A `load` in the middle of a stream, including one on an edge where `bit_rdy` is high, restarts the selected pattern at its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 3 | Pattern type code (0..7) |
| cfg_len | input | 5 | Repeating word length minus one |
| cfg_word | input | 32 | Repeating word contents |
| cfg_alt_a | input | 16 | First alternating word |
| cfg_alt_b | input | 16 | Second alternating word |
| cfg_flip | input | 8 | Repetitions per alternating word, minus one |
| load | input | 1 | Capture configuration and restart the stream |
| bit_rdy | input | 1 | Sink ready: takes the current bit |
| bit_vld | output | 1 | Stream valid, high from the cycle after the first load |
| bit_out | output | 1 | Current stream bit |

## Verification
The bench builds the block with a 3-bit repetition count, so all eight flip counts of the alternating mode are swept exhaustively. It keeps the full 32-bit repeating word, so every repeat length from 1 to 32 is covered. The quasi-random mode runs for 140,000 bits against a model computed from the recurrence. That run is long enough to reach zero runs of 14 or more, where the forcing rule applies. The pseudorandom modes run with irregular stalls to cover the hold behaviour.

// File: rtl/bert_tx_pkg.sv
package bert_tx_pkg;

  typedef enum logic [2:0] {
    PAT_PRBS7  = 3'd0,
    PAT_PRBS11 = 3'd1,
    PAT_PRBS15 = 3'd2,
    PAT_QRSS   = 3'd3,
    PAT_REPEAT = 3'd4,
    PAT_ALT    = 3'd5
  } pat_e;

  // shared shift register width and zero-run length for the quasi-random mode
  localparam int unsigned LFSR_W   = 20;
  localparam int unsigned QRSS_RUN = 14;
  localparam int unsigned NPOLY    = 4;

  // register length of polynomial g (indexed by the low bits of the mode code)
  function automatic int unsigned poly_len(int unsigned g);
    case (g)
      0:       return 7;
      1:       return 11;
      2:       return 15;
      default: return 20;
    endcase
  endfunction

  // middle tap exponent of polynomial g
  function automatic int unsigned poly_tap(int unsigned g);
    case (g)
      0:       return 6;
      1:       return 9;
      2:       return 14;
      default: return 17;
    endcase
  endfunction

endpackage

// File: rtl/bert_prbs_core.sv
module bert_prbs_core
  import bert_tx_pkg::*;
#(
  parameter int unsigned W   = LFSR_W,
  parameter int unsigned RUN = QRSS_RUN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seed,
  input  logic       step,
  input  logic [1:0] poly_sel,
  output logic       bit_o
);

  logic [W-1:0]     s_q;
  logic [NPOLY-1:0] fb_v;
  logic [NPOLY-1:0] head_v;
  logic             zero_run;

  // one feedback network per polynomial, all on the same register
  for (genvar g = 0; g < NPOLY; g++) begin : g_poly
    localparam int unsigned PL = poly_len(g);
    localparam int unsigned PT = poly_tap(g);
    assign fb_v[g]   = s_q[PL-1] ^ s_q[PT-1];
    assign head_v[g] = s_q[PL-1];
  end

  // the top RUN bits are the current bit and the RUN-1 that follow it
  assign zero_run = ~|s_q[W-1 -: RUN];

  always_comb begin
    if (poly_sel == PAT_QRSS[1:0]) bit_o = head_v[NPOLY-1] | zero_run;
    else                           bit_o = head_v[poly_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    s_q <= '1;
    else if (seed) s_q <= '1;
    else if (step) s_q <= {s_q[W-2:0], fb_v[poly_sel]};
  end

endmodule

// File: rtl/bert_word_seq.sv
module bert_word_seq #(
  parameter int unsigned REP_MAX = 32,
  parameter int unsigned ALT_W   = 16,
  parameter int unsigned CNT_W   = 8,
  localparam int unsigned LEN_W  = $clog2(REP_MAX),
  localparam int unsigned AIDX_W = $clog2(ALT_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               alt_i,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [REP_MAX-1:0] cfg_word,
  input  logic [ALT_W-1:0]   cfg_alt_a,
  input  logic [ALT_W-1:0]   cfg_alt_b,
  input  logic [CNT_W-1:0]   cfg_flip,
  output logic               bit_o
);

  localparam logic [LEN_W-1:0] ALT_TOP = LEN_W'(ALT_W - 1);

  logic               alt_q;
  logic [LEN_W-1:0]   len_q;
  logic [REP_MAX-1:0] word_q;
  logic [ALT_W-1:0]   a_q;
  logic [ALT_W-1:0]   b_q;
  logic [CNT_W-1:0]   flip_q;
  logic [LEN_W-1:0]   ptr_q;
  logic [CNT_W-1:0]   wcnt_q;
  logic               sel_q;
  logic [LEN_W-1:0]   top_q;

  assign top_q = alt_q ? ALT_TOP : len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q  <= 1'b0;
      len_q  <= '0;
      word_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      flip_q <= '0;
      ptr_q  <= '0;
      wcnt_q <= '0;
      sel_q  <= 1'b0;
    end else if (load) begin
      alt_q  <= alt_i;
      len_q  <= cfg_len;
      word_q <= cfg_word;
      a_q    <= cfg_alt_a;
      b_q    <= cfg_alt_b;
      flip_q <= cfg_flip;
      ptr_q  <= alt_i ? ALT_TOP : cfg_len;
      wcnt_q <= '0;
      sel_q  <= 1'b0;
    end else if (step) begin
      if (ptr_q == '0) begin
        ptr_q <= top_q;
        if (alt_q) begin
          if (wcnt_q == flip_q) begin
            wcnt_q <= '0;
            sel_q  <= ~sel_q;
          end else begin
            wcnt_q <= wcnt_q + CNT_W'(1);
          end
        end
      end else begin
        ptr_q <= ptr_q - LEN_W'(1);
      end
    end
  end

  always_comb begin
    if (alt_q) bit_o = sel_q ? b_q[ptr_q[AIDX_W-1:0]] : a_q[ptr_q[AIDX_W-1:0]];
    else       bit_o = word_q[ptr_q];
  end

endmodule

// File: rtl/bert_tx_gen.sv
module bert_tx_gen
  import bert_tx_pkg::*;
#(
  parameter int unsigned REP_MAX = 32,
  parameter int unsigned ALT_W   = 16,
  parameter int unsigned CNT_W   = 8,
  localparam int unsigned LEN_W  = $clog2(REP_MAX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cfg_mode,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [REP_MAX-1:0] cfg_word,
  input  logic [ALT_W-1:0]   cfg_alt_a,
  input  logic [ALT_W-1:0]   cfg_alt_b,
  input  logic [CNT_W-1:0]   cfg_flip,
  input  logic               load,
  input  logic               bit_rdy,
  output logic               bit_vld,
  output logic               bit_out
);

  logic [2:0] mode_q;
  logic       vld_q;
  logic       step;
  logic       lfsr_mode;
  logic       lfsr_bit;
  logic       word_bit;
  logic       pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      vld_q  <= 1'b0;
    end else if (load) begin
      mode_q <= cfg_mode;
      vld_q  <= 1'b1;
    end
  end

  assign step      = vld_q & bit_rdy & ~load;
  assign lfsr_mode = (mode_q < PAT_REPEAT);

  bert_prbs_core #(
    .W   (LFSR_W),
    .RUN (QRSS_RUN)
  ) u_prbs (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed     (load),
    .step     (step & lfsr_mode),
    .poly_sel (mode_q[1:0]),
    .bit_o    (lfsr_bit)
  );

  bert_word_seq #(
    .REP_MAX (REP_MAX),
    .ALT_W   (ALT_W),
    .CNT_W   (CNT_W)
  ) u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .alt_i     (cfg_mode == PAT_ALT),
    .cfg_len   (cfg_len),
    .cfg_word  (cfg_word),
    .cfg_alt_a (cfg_alt_a),
    .cfg_alt_b (cfg_alt_b),
    .cfg_flip  (cfg_flip),
    .bit_o     (word_bit)
  );

  always_comb begin
    case (mode_q)
      PAT_PRBS7, PAT_PRBS11, PAT_PRBS15, PAT_QRSS: pick = lfsr_bit;
      PAT_REPEAT, PAT_ALT:                         pick = word_bit;
      default:                                     pick = 1'b0;
    endcase
  end

  assign bit_vld = vld_q;
  assign bit_out = vld_q & pick;

endmodule

// File: rtl/bert_tx_gen_chk.sv
module bert_tx_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic       bit_rdy,
  input logic       bit_vld,
  input logic       bit_out,
  input logic [2:0] mode
);

  AST_IDLE_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !load) |=> (!bit_vld && !bit_out)); // R1

  AST_LOAD_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bit_vld); // R2

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !bit_rdy && !load) |=> $stable(bit_out)); // R3

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && mode > 3'd5) |-> !bit_out); // R10

endmodule

module bert_prbs_core_chk #(
  parameter int unsigned W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         seed,
  input logic [W-1:0] s_q
);

  AST_LFSR_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    s_q != '0); // R4

  AST_SEED_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> (&s_q)); // R11

endmodule

bind bert_tx_gen bert_tx_gen_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .load    (load),
  .bit_rdy (bit_rdy),
  .bit_vld (bit_vld),
  .bit_out (bit_out),
  .mode    (mode_q)
);

bind bert_prbs_core bert_prbs_core_chk #(.W(W)) chk_core_i (
  .clk   (clk),
  .rst_n (rst_n),
  .seed  (seed),
  .s_q   (s_q)
);

// File: tb/bert_tx_gen_tb_top.sv
`timescale 1ns/1ps
module bert_tx_gen_tb_top;

  localparam int unsigned REP_MAX = 32;
  localparam int unsigned ALT_W   = 16;
  localparam int unsigned CNT_W   = 3;
  localparam int unsigned LEN_W   = 5;
  localparam int          QN      = 140000;
  localparam int          NB      = QN + 40;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [2:0]         cfg_mode = '0;
  logic [LEN_W-1:0]   cfg_len = '0;
  logic [REP_MAX-1:0] cfg_word = '0;
  logic [ALT_W-1:0]   cfg_alt_a = '0;
  logic [ALT_W-1:0]   cfg_alt_b = '0;
  logic [CNT_W-1:0]   cfg_flip = '0;
  logic               load = 1'b0;
  logic               bit_rdy = 1'b0;
  logic               bit_vld;
  logic               bit_out;

  int checks = 0;
  int errors = 0;
  bit raw_b [NB];
  bit exp_b [NB];

  always #10 clk = ~clk;

  bert_tx_gen #(
    .REP_MAX (REP_MAX),
    .ALT_W   (ALT_W),
    .CNT_W   (CNT_W)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .cfg_len   (cfg_len),
    .cfg_word  (cfg_word),
    .cfg_alt_a (cfg_alt_a),
    .cfg_alt_b (cfg_alt_b),
    .cfg_flip  (cfg_flip),
    .load      (load),
    .bit_rdy   (bit_rdy),
    .bit_vld   (bit_vld),
    .bit_out   (bit_out)
  );

  task automatic chk(bit ok, string req, int idx, logic act, logic expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0d: got %0b expected %0b", req, idx, act, expv);
    end
  endtask

  // sequence with b0..b(n-1)=1 and b(k+n) = b(k) ^ b(k+d)
  task automatic build_lfsr(int n, int d, int cnt);
    for (int i = 0; i < cnt; i++) begin
      raw_b[i] = (i < n) ? 1'b1 : (raw_b[i-n] ^ raw_b[i-n+d]);
      exp_b[i] = raw_b[i];
    end
  endtask

  // caller is at a falling edge
  task automatic do_load(logic [2:0] m, logic [LEN_W-1:0] ln, logic [REP_MAX-1:0] w,
                         logic [ALT_W-1:0] a, logic [ALT_W-1:0] b, logic [CNT_W-1:0] f);
    cfg_mode  = m;
    cfg_len   = ln;
    cfg_word  = w;
    cfg_alt_a = a;
    cfg_alt_b = b;
    cfg_flip  = f;
    load      = 1'b1;
    @(negedge clk);
    load      = 1'b0;
    chk(bit_vld === 1'b1, "R2", 0, bit_vld, 1'b1);
  endtask

  // checks exp_b[k0..n-1]; a bit is taken on each cycle where bit_rdy is driven high
  task automatic run_stream(int k0, int n, int stall_mod, string req);
    int k = k0;
    int cyc = 0;
    while (k < n) begin
      chk(bit_vld === 1'b1 && bit_out === exp_b[k], req, k, bit_out, exp_b[k]);
      bit_rdy = (stall_mod == 0) || ((cyc % stall_mod) != 0);
      @(negedge clk);
      if (bit_rdy) k++;
      cyc++;
    end
    bit_rdy = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog: got run still active expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [REP_MAX-1:0] w;
    int forced;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle before the first load, even when the sink is ready
    bit_rdy = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(bit_vld === 1'b0 && bit_out === 1'b0, "R1", i, bit_out, 1'b0);
      @(negedge clk);
    end
    bit_rdy = 1'b0;

    // R4/R5/R6: pseudorandom modes with stalls (R3)
    build_lfsr(7, 1, 400);
    do_load(3'd0, '0, '0, '0, '0, '0);
    run_stream(0, 300, 3, "R4");
    for (int i = 0; i < 127; i++)
      chk(exp_b[i] == exp_b[i+127], "R4", i, exp_b[i+127], exp_b[i]);
    build_lfsr(11, 2, 400);
    do_load(3'd1, '0, '0, '0, '0, '0);
    run_stream(0, 300, 4, "R5");
    build_lfsr(15, 1, 400);
    do_load(3'd2, '0, '0, '0, '0, '0);
    run_stream(0, 200, 5, "R6");
    // R11: restart mid-stream with the sink ready on the load edge
    bit_rdy = 1'b1;
    do_load(3'd2, '0, '0, '0, '0, '0);
    run_stream(0, 100, 3, "R11");

    // R3: long stall holds the bit
    build_lfsr(7, 1, 40);
    do_load(3'd0, '0, '0, '0, '0, '0);
    run_stream(0, 9, 0, "R3");
    for (int i = 0; i < 6; i++) begin
      chk(bit_out === exp_b[9], "R3", 9, bit_out, exp_b[9]);
      @(negedge clk);
    end
    run_stream(9, 30, 0, "R3");

    // R8: every repeat length
    for (int L = 1; L <= 32; L++) begin
      w = 32'hB4C3_5A1D ^ (32'(L) * 32'h0101_0107);
      for (int k = 0; k < 2*L + 3; k++) exp_b[k] = w[L-1-(k % L)];
      do_load(3'd4, LEN_W'(L-1), w, '0, '0, '0);
      run_stream(0, 2*L + 3, 3, "R8");
    end

    // R2: configuration changes without load are ignored
    w = 32'h0000_0016;
    for (int k = 0; k < 40; k++) exp_b[k] = w[4-(k % 5)];
    do_load(3'd4, LEN_W'(4), w, '0, '0, '0);
    run_stream(0, 12, 0, "R8");
    cfg_word  = ~w;
    cfg_len   = '1;
    cfg_mode  = 3'd0;
    cfg_alt_a = 16'hFFFF;
    run_stream(12, 40, 2, "R2");

    // R9: every flip count of the small configuration
    for (int f = 0; f < (1 << CNT_W); f++) begin
      logic [ALT_W-1:0] a;
      logic [ALT_W-1:0] b;
      int nb;
      a  = 16'hA5C3 ^ 16'(f);
      b  = 16'h3C96 ^ 16'(f << 4);
      nb = 4 * (f + 1) * 16 + 16;
      for (int k = 0; k < nb; k++)
        exp_b[k] = (((k / 16) / (f + 1)) % 2 == 1) ? b[15 - (k % 16)] : a[15 - (k % 16)];
      do_load(3'd5, '0, '0, a, b, CNT_W'(f));
      run_stream(0, nb, 4, "R9");
    end

    // R10: reserved codes are silent
    for (int i = 0; i < 40; i++) exp_b[i] = 1'b0;
    do_load(3'd6, '1, '1, '1, '1, '1);
    run_stream(0, 20, 3, "R10");
    do_load(3'd7, '1, '1, '1, '1, '1);
    run_stream(0, 20, 0, "R10");

    // R7: quasi-random run with zero-run forcing
    for (int i = 0; i < QN + 20; i++)
      raw_b[i] = (i < 20) ? 1'b1 : (raw_b[i-20] ^ raw_b[i-17]);
    forced = 0;
    for (int k = 0; k < QN; k++) begin
      bit any;
      any = 1'b0;
      for (int j = 0; j < 14; j++) any = any | raw_b[k+j];
      exp_b[k] = raw_b[k] | ~any;
      if (!any) forced++;
    end
    $display("info: quasi-random run contains %0d forced ones", forced);
    do_load(3'd3, '0, '0, '0, '0, '0);
    run_stream(0, QN, 0, "R7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule